// File: doc/BRIEF.md
# UART Hardware Handshake Flow Controller

This block provides automatic modem-line flow control for a single UART channel. On the transmit side, it watches the active-low clear-to-send pin from the remote end. When the remote end deasserts that pin, the block withdraws its permission to start a new character. A character that is already being shifted out is never cut short: the block halts only at a character boundary. The serializer reports when it starts a character and when it finishes one, so the block knows where the boundaries are.

On the receive side, the block drives the active-low request-to-send pin from the fill level of the receive FIFO. Two programmable thresholds give the output hysteresis. When automatic control is switched off, the pin instead follows a request bit that software sets. Each direction has its own enable, and both enables are off after reset.

The serializer may start a character only in a cycle where `tx_permit` is high and no character is in flight. The fill level and the thresholds come from the FIFO and from the configuration registers.

Top module: `uart_hwflow_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_permit` reads 1 and `rts_n` reads 1.
- R2: With `cts_en` low, `tx_permit` stays 1 whatever level `cts_n` has.
- R3: With `cts_en` high and no character in flight, `tx_permit` falls on the third rising clock edge after `cts_n` goes high. It rises again on the third rising edge after `cts_n` goes low. The first two of those edges pass the pin through a two-flop synchronizer.
- R4: While a character is in flight (between an accepted `tx_start` and the matching `char_done`), `tx_permit` stays 1 even if a halt is requested. It falls on the edge that samples `char_done`.
- R5: With `rts_en` high, when `rx_level` is strictly greater than `thr_high`, `rts_n` is 1 after the next rising edge.
- R6: With `rts_en` high, when `rx_level` is strictly less than `thr_low` and not above `thr_high`, `rts_n` is 0 after the next rising edge.
- R7: With `rts_en` high, a level from `thr_low` to `thr_high` inclusive leaves `rts_n` at its previous value.
- R8: If `thr_low` is not below `thr_high`, a level above `thr_high` drives `rts_n` to 1 even when that level is also below `thr_low`.
- R9: With `rts_en` low, `rts_n` equals the inverse of `sw_rts_req` one edge later. The hysteresis state keeps tracking the FIFO level meanwhile, so enabling `rts_en` shows the tracked state at once.
- R10: `rx_level` is one bit wider than the thresholds. A full level of 256 counts as above a `thr_high` of 255, and a level of 255 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_en | input | 1 | Enables automatic transmit halting from the clear-to-send pin |
| rts_en | input | 1 | Enables automatic request-to-send from the receive fill level |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| rx_level | input | 9 | Receive FIFO fill count, 0 to 256 |
| thr_high | input | 8 | Upper fill threshold |
| thr_low | input | 8 | Lower fill threshold |
| sw_rts_req | input | 1 | Software request bit; 1 asks for the line to be asserted (low) |
| tx_start | input | 1 | One-cycle strobe: serializer begins a character |
| char_done | input | 1 | One-cycle strobe: serializer finished its stop bit |
| tx_permit | output | 1 | 1 allows the serializer to start a new character |
| rts_n | output | 1 | Active-low request-to-send pin |

## Verification
The assertions assume that the serializer raises `tx_start` only while `tx_permit` is high and it is idle. They also assume that `char_done` arrives only for a character that was started, and that `rx_level` never exceeds 256. The stimulus keeps to these rules. It issues a single start from the idle state, ends that character with exactly one done strobe, and holds every strobe for one cycle. It changes the fill level and thresholds only between edges, and always to values inside their ranges. Threshold pairs include both the ordered and the inverted case, so the priority rule is exercised without breaking the rules above.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;

    localparam int unsigned THR_BITS    = 8;
    localparam int unsigned LEVEL_BITS  = THR_BITS + 1;
    localparam int unsigned SYNC_DEPTH  = 2;

    // Receive-side line state: OPEN keeps RTS# low, FULL drives it high
    typedef enum logic {
        RX_OPEN = 1'b0,
        RX_FULL = 1'b1
    } rx_gate_e;

    typedef struct packed {
        logic above;
        logic below;
    } lvl_cmp_t;

    // Hysteresis step: the upper condition wins when both hold
    function automatic rx_gate_e hyst_step(rx_gate_e cur, lvl_cmp_t c);
        if (c.above)
            return RX_FULL;
        else if (c.below)
            return RX_OPEN;
        else
            return cur;
    endfunction

    // Transmit permit step: drop only at a character boundary
    function automatic logic permit_step(logic halt, logic permit, logic busy,
                                         logic start, logic done);
        if (!halt)
            return 1'b1;
        else
            return permit & (busy | start) & ~done;
    endfunction

endpackage

// File: rtl/hwflow_cts_sync.sv
module hwflow_cts_sync #(
    parameter int unsigned STAGES = hwflow_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_n_s
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_n_s = chain_q[STAGES-1];

endmodule

// File: rtl/hwflow_tx_gate.sv
module hwflow_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic tx_start,
    input  logic char_done,
    output logic tx_permit
);
    import hwflow_pkg::*;

    logic permit_q, busy_q;
    logic permit_d, busy_d, start_ok;

    assign start_ok = tx_start & permit_q;

    always_comb begin
        if (start_ok)       busy_d = 1'b1;
        else if (char_done) busy_d = 1'b0;
        else                busy_d = busy_q;
        permit_d = permit_step(halt_req, permit_q, busy_q, start_ok, char_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            permit_q <= 1'b1;
            busy_q   <= 1'b0;
        end else begin
            permit_q <= permit_d;
            busy_q   <= busy_d;
        end
    end

    assign tx_permit = permit_q;

    // R3: without a halt request the permit is restored on the next edge
    a_r3_resume: assert property (@(posedge clk) disable iff (rst)
        !halt_req |=> tx_permit);

    // R3: the permit never falls unless a halt was requested
    a_r3_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(permit_q) |-> $past(halt_req));

    // R4: a character in flight keeps the permit up until it is done
    a_r4_boundary: assert property (@(posedge clk) disable iff (rst)
        (busy_q && permit_q && !char_done) |=> tx_permit);

    // R4: a fall happens only at a boundary (done strobe or idle)
    a_r4_fall_at_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(permit_q) |-> ($past(char_done) || !$past(busy_q)));

endmodule

// File: rtl/hwflow_rts_hyst.sv
module hwflow_rts_hyst #(
    parameter int unsigned THR_W = hwflow_pkg::THR_BITS,
    parameter int unsigned LVL_W = THR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rts_en,
    input  logic             sw_rts_req,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] thr_high,
    input  logic [THR_W-1:0] thr_low,
    output logic             rts_n
);
    import hwflow_pkg::*;

    logic [LVL_W-1:0] high_ext, low_ext;
    lvl_cmp_t         cmp;
    rx_gate_e         state_q, state_d;
    logic             rts_n_q;

    assign high_ext = LVL_W'(thr_high);
    assign low_ext  = LVL_W'(thr_low);

    always_comb begin
        cmp.above = (rx_level > high_ext);
        cmp.below = (rx_level < low_ext);
        state_d   = hyst_step(state_q, cmp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_OPEN;
            rts_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            rts_n_q <= rts_en ? logic'(state_d) : ~sw_rts_req;
        end
    end

    assign rts_n = rts_n_q;

    // R5 / R8: above the upper threshold always means full
    a_r5_full: assert property (@(posedge clk) disable iff (rst)
        cmp.above |=> (state_q == RX_FULL));

    // R5: automatic mode drives the pin high when above the upper threshold
    a_r5_pin: assert property (@(posedge clk) disable iff (rst)
        (rts_en && cmp.above) |=> rts_n);

    // R6: below the lower threshold (and not above the upper) reopens
    a_r6_open: assert property (@(posedge clk) disable iff (rst)
        (!cmp.above && cmp.below) |=> (state_q == RX_OPEN));

    // R7: inside the band the state is held
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmp.above && !cmp.below) |=> $stable(state_q));

endmodule

// File: rtl/uart_hwflow_ctrl.sv
module uart_hwflow_ctrl #(
    parameter int unsigned THR_W       = hwflow_pkg::THR_BITS,
    parameter int unsigned LVL_W       = THR_W + 1,
    parameter int unsigned SYNC_STAGES = hwflow_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cts_en,
    input  logic             rts_en,
    input  logic             cts_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] thr_high,
    input  logic [THR_W-1:0] thr_low,
    input  logic             sw_rts_req,
    input  logic             tx_start,
    input  logic             char_done,
    output logic             tx_permit,
    output logic             rts_n
);

    logic cts_n_s;
    logic halt_req;

    hwflow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (cts_n),
        .pin_n_s (cts_n_s)
    );

    assign halt_req = cts_en & cts_n_s;

    hwflow_tx_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .halt_req  (halt_req),
        .tx_start  (tx_start),
        .char_done (char_done),
        .tx_permit (tx_permit)
    );

    hwflow_rts_hyst #(.THR_W(THR_W), .LVL_W(LVL_W)) u_rts (
        .clk        (clk),
        .rst        (rst),
        .rts_en     (rts_en),
        .sw_rts_req (sw_rts_req),
        .rx_level   (rx_level),
        .thr_high   (thr_high),
        .thr_low    (thr_low),
        .rts_n      (rts_n)
    );

    // R1: outputs leave reset in the released state
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (tx_permit && rts_n));

    // R2: with automatic CTS off the permit is always granted
    a_r2_cts_off: assert property (@(posedge clk) disable iff (rst)
        !cts_en |=> tx_permit);

    // R9: with automatic RTS off the pin mirrors the software request
    a_r9_manual: assert property (@(posedge clk) disable iff (rst)
        !rts_en |=> (rts_n == ~$past(sw_rts_req)));

endmodule

// File: tb/uart_hwflow_ctrl_test.sv
`timescale 1ns/1ps
module uart_hwflow_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cts_en, rts_en, cts_n, sw_rts_req, tx_start, char_done;
    logic [8:0] rx_level;
    logic [7:0] thr_high, thr_low;
    logic       tx_permit, rts_n;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        string tag;
        bit    is_rts;
        logic  val;
    } want_t;

    want_t q[$];
    want_t item;

    always #2 clk = ~clk;

    uart_hwflow_ctrl uut (
        .clk(clk), .rst(rst), .cts_en(cts_en), .rts_en(rts_en), .cts_n(cts_n),
        .rx_level(rx_level), .thr_high(thr_high), .thr_low(thr_low),
        .sw_rts_req(sw_rts_req), .tx_start(tx_start), .char_done(char_done),
        .tx_permit(tx_permit), .rts_n(rts_n)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic want(string tag, bit is_rts, logic v);
        q.push_back('{tag, is_rts, v});
    endtask

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item = q.pop_front();
            n_checks++;
            if (item.is_rts) begin
                if (rts_n !== item.val) begin
                    n_fail++;
                    $display("FAIL %s rts_n actual=%b expected=%b", item.tag, rts_n, item.val);
                end
            end else begin
                if (tx_permit !== item.val) begin
                    n_fail++;
                    $display("FAIL %s tx_permit actual=%b expected=%b", item.tag, tx_permit, item.val);
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cts_en = 1'b0; rts_en = 1'b0; cts_n = 1'b0;
        sw_rts_req = 1'b0; tx_start = 1'b0; char_done = 1'b0;
        rx_level = 9'd0; thr_high = 8'd200; thr_low = 8'd100;
        tick(3);
        want("R1", 0, 1'b1); want("R1", 1, 1'b1);
        rst = 1'b0;
        tick(1);
        want("R1", 0, 1'b1); want("R1", 1, 1'b1);

        // R9: manual request path
        sw_rts_req = 1'b1; tick(1); want("R9", 1, 1'b0);
        sw_rts_req = 1'b0; tick(1); want("R9", 1, 1'b1);

        // R2: pin ignored while disabled
        cts_n = 1'b1; tick(4); want("R2", 0, 1'b1);
        cts_n = 1'b0; tick(4); want("R2", 0, 1'b1);

        // R3: synchronized halt and resume when idle
        cts_en = 1'b1; tick(2); want("R3", 0, 1'b1);
        cts_n = 1'b1;
        tick(2); want("R3", 0, 1'b1);
        tick(1); want("R3", 0, 1'b0);
        cts_n = 1'b0;
        tick(2); want("R3", 0, 1'b0);
        tick(1); want("R3", 0, 1'b1);

        // R4: halt waits for the character boundary
        tx_start = 1'b1; tick(1); tx_start = 1'b0;
        cts_n = 1'b1;
        tick(3); want("R4", 0, 1'b1);
        tick(2); want("R4", 0, 1'b1);
        char_done = 1'b1; tick(1); char_done = 1'b0;
        want("R4", 0, 1'b0);
        cts_n = 1'b0; tick(3); want("R4", 0, 1'b1);

        // R5 / R6 / R7: hysteresis with 100..200 band
        rts_en = 1'b1;
        rx_level = 9'd50;  tick(1); want("R6", 1, 1'b0);
        rx_level = 9'd150; tick(1); want("R7", 1, 1'b0);
        rx_level = 9'd201; tick(1); want("R5", 1, 1'b1);
        rx_level = 9'd200; tick(1); want("R7", 1, 1'b1);
        rx_level = 9'd150; tick(1); want("R7", 1, 1'b1);
        rx_level = 9'd100; tick(1); want("R7", 1, 1'b1);
        rx_level = 9'd99;  tick(1); want("R6", 1, 1'b0);

        // R8: inverted thresholds, upper wins
        thr_high = 8'd50; thr_low = 8'd150;
        rx_level = 9'd100; tick(1); want("R8", 1, 1'b1);
        rx_level = 9'd40;  tick(1); want("R8", 1, 1'b0);
        rx_level = 9'd100; tick(1); want("R8", 1, 1'b1);

        // R10: full FIFO against the largest threshold
        thr_high = 8'd255; thr_low = 8'd10;
        rx_level = 9'd5;   tick(1); want("R10", 1, 1'b0);
        rx_level = 9'd255; tick(1); want("R10", 1, 1'b0);
        rx_level = 9'd256; tick(1); want("R10", 1, 1'b1);

        // R9: state tracks while disabled, shows on enable
        rts_en = 1'b0; sw_rts_req = 1'b1;
        rx_level = 9'd5;   tick(1); want("R9", 1, 1'b0);
        rx_level = 9'd256; tick(1); want("R9", 1, 1'b0);
        rx_level = 9'd100; tick(1); want("R9", 1, 1'b0);
        rts_en = 1'b1;     tick(1); want("R9", 1, 1'b1);

        @(negedge clk); @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule